// File: doc/BRIEF.md
# Three-Level Phase Modulator with Stacked Carriers

This block decides the switching state of one leg of a three-level, neutral-clamped inverter. It makes a triangular carrier internally and sees it twice: once as an upper band from zero to positive full scale, and once shifted down into a lower band from negative full scale to zero. A signed reference sample is compared against both bands. The result is a three-valued level: positive rail, neutral, or negative rail.

From the level it drives four gate signals, arranged as two complementary pairs. The outer pair connects the output to the positive rail only for the positive level. The inner pair keeps the output off the negative rail unless the level is negative. Each pair inserts a programmable dead time before any gate turns on. Full scale equals the programmed carrier half-period in counts. A modulator or current controller supplies the reference, and the gate outputs go to the drivers.

Top module: `tlpwm_phase`

## Requirements
- R1: While enabled with a fixed `period` P (P >= 1), the internal count starts at 0 and moves by exactly one each cycle: 0, 1, …, P, P-1, …, 1, 0, 1, … (2P cycles per carrier cycle). The upper carrier equals the count, and the lower carrier equals the count minus P.
- R2: If the held reference is strictly greater than the upper carrier, `state_code` becomes 2'b01 (positive) one cycle later.
- R3: If the held reference lies between the lower and upper carriers, both bounds included, `state_code` becomes 2'b00 (neutral) one cycle later.
- R4: If the held reference is strictly less than the lower carrier, `state_code` becomes 2'b11 (negative) one cycle later.
- R5: `ref_in` is captured only on the cycle in which the count equals P, which is the carrier peak. Changes at any other time have no effect on `state_code` until the next capture.
- R6: The outer pair is driven so that `gate_a_hi` is commanded on for the positive level and `gate_a_lo` for the other levels. The inner pair is driven so that `gate_b_hi` is commanded on for any non-negative level and `gate_b_lo` for the negative level. Both gates of one pair are never on together, and gates follow `state_code` one cycle later.
- R7: A gate turns on only once its command has been the same for `dead`+1 consecutive enabled cycles. A gate turns off in the first cycle its command drops, so each change leaves both gates of that pair off for `dead` cycles.
- R8: While `en` is low, all four gates are off, `state_code` is 2'b00, the held reference is cleared to 0, and the count restarts at 0 once `en` rises.
- R9: Synchronous reset `rst` puts the block into the same state as a low `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces all gates off |
| ref_in | input | REF_W (12) | Signed reference sample, full scale ±period |
| period | input | CNT_W (11) | Carrier half-period in cycles, at least 1 |
| dead | input | DT_W (4) | Dead time in cycles |
| state_code | output | 2 | Level: 01 positive, 00 neutral, 11 negative |
| gate_a_hi | output | 1 | Outer pair, rail-side gate |
| gate_a_lo | output | 1 | Outer pair, complementary gate |
| gate_b_hi | output | 1 | Inner pair, rail-side gate |
| gate_b_lo | output | 1 | Inner pair, complementary gate |

## Verification
A wrong count or a missed peak capture shows up in `state_code` within one carrier cycle. In the sweep, every reference value from below negative full scale to above positive full scale is held across a full triangle, so the boundary cycles where reference equals a carrier show a misclassification. A run-length error in a dead-time pair shows on the gate pins on the first level change after enable, as early or late turn-on or as an overlap. A reference that leaks through outside the peak makes `state_code` diverge during the phase where the reference changes every cycle.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } lvl_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    localparam int NUM_PAIRS = 2;

    function automatic lvl_t classify(input int r, input int up, input int low);
        if (r > up)
            return LVL_POS;
        else if (r < low)
            return LVL_NEG;
        else
            return LVL_ZERO;
    endfunction

    function automatic logic pair_cmd(input int idx, input lvl_t lvl);
        if (idx == 0)
            return lvl == LVL_POS;
        else
            return lvl != LVL_NEG;
    endfunction

endpackage

// File: rtl/tl_carrier.sv
module tl_carrier #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             peak
);
    logic rising;

    assign peak = rising && (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt >= period) begin
                if (cnt != '0) begin
                    cnt    <= cnt - 1'b1;
                    rising <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                cnt    <= cnt + 1'b1;
                rising <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R1: with a nonzero period the count steps by exactly one each enabled cycle
    a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst) && period != '0 && $stable(period))
        |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tl_deadtime.sv
module tl_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            cmd,
    input  logic [DT_W-1:0] dead,
    output logic            hi,
    output logic            lo
);
    localparam int RUN_W = DT_W + 1;

    logic [RUN_W-1:0] run, run_next;
    logic             prev;
    logic             settled;

    always_comb begin
        if (run != '0 && cmd == prev)
            run_next = (run == '1) ? run : run + 1'b1;
        else
            run_next = RUN_W'(1);
        settled = run_next > {1'b0, dead};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run  <= '0;
            prev <= 1'b0;
            hi   <= 1'b0;
            lo   <= 1'b0;
        end else begin
            run  <= run_next;
            prev <= cmd;
            hi   <= cmd && settled;
            lo   <= !cmd && settled;
        end
    end

    // R6: the two gates of a pair are never on together
    a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hi && lo));

    // R7: with a nonzero dead time a gate only rises after its command was already present
    a_r7_rise_waits: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi) && dead != '0 && $stable(dead)) |-> ($past(cmd) && $past(en)));

endmodule

// File: rtl/tlpwm_phase.sv
module tlpwm_phase #(
    parameter int REF_W = 12,
    parameter int CNT_W = 11,
    parameter int DT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic        [CNT_W-1:0] period,
    input  logic        [DT_W-1:0]  dead,
    output logic        [1:0]       state_code,
    output logic                    gate_a_hi,
    output logic                    gate_a_lo,
    output logic                    gate_b_hi,
    output logic                    gate_b_lo
);
    import tlpwm_pkg::*;

    logic [CNT_W-1:0]        cnt;
    logic                    peak;
    logic signed [REF_W-1:0] ref_q;
    lvl_t                    lvl_q;
    int                      up_c, low_c;
    gate_pair_t              pairs [NUM_PAIRS];

    tl_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .period (period),
        .cnt    (cnt),
        .peak   (peak)
    );

    always_comb begin
        up_c  = int'($signed({1'b0, cnt}));
        low_c = up_c - int'($signed({1'b0, period}));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ref_q <= '0;
            lvl_q <= LVL_ZERO;
        end else begin
            if (peak)
                ref_q <= ref_in;
            lvl_q <= classify(int'(ref_q), up_c, low_c);
        end
    end

    generate
        for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
            tl_deadtime #(.DT_W(DT_W)) u_dt (
                .clk  (clk),
                .rst  (rst),
                .en   (en),
                .cmd  (pair_cmd(g, lvl_q)),
                .dead (dead),
                .hi   (pairs[g].hi),
                .lo   (pairs[g].lo)
            );
        end
    endgenerate

    assign state_code = lvl_q;
    assign gate_a_hi  = pairs[0].hi;
    assign gate_a_lo  = pairs[0].lo;
    assign gate_b_hi  = pairs[1].hi;
    assign gate_b_lo  = pairs[1].lo;

    // R8: one cycle after enable is low, all gates are off and the level is neutral
    a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_code == 2'b00 && !gate_a_hi && !gate_a_lo && !gate_b_hi && !gate_b_lo));

    // R5: away from the peak the held reference does not move
    a_r5_hold_off_peak: assert property (@(posedge clk) disable iff (rst)
        (en && !peak) |=> (!en || $stable(ref_q)));

    // R6: the outer rail gate and the inner negative gate are never on together
    a_r6_no_cross_rail: assert property (@(posedge clk) disable iff (rst)
        !(gate_a_hi && gate_b_lo));

endmodule

// File: tb/sim_tlpwm_phase.sv
module sim_tlpwm_phase;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W = 12;
    localparam int CNT_W = 11;
    localparam int DT_W  = 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic signed [REF_W-1:0] ref_in = '0;
    logic        [CNT_W-1:0] period = CNT_W'(3);
    logic        [DT_W-1:0]  dead   = '0;
    logic [1:0]              state_code;
    logic                    gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

    int  n_run = 0;
    int  n_fail = 0;
    bit  checking = 1'b0;
    bit  wobble = 1'b0;
    bit  done = 1'b0;

    tlpwm_phase #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) u0 (
        .clk(clk), .rst(rst), .en(en), .ref_in(ref_in), .period(period), .dead(dead),
        .state_code(state_code), .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected behaviour from the requirements
    int m_n = 0, m_ref = 0, m_lvl = 0;
    int m_run [2] = '{0, 0};
    bit m_prev [2] = '{0, 0};
    bit m_hi [2] = '{0, 0};
    bit m_lo [2] = '{0, 0};

    function automatic int tri_at(input int n, input int p);
        int ph;
        ph = n % (2 * p);
        return (ph <= p) ? ph : 2 * p - ph;
    endfunction

    function automatic int level_of(input int r, input int c, input int p);
        if (r > c) return 1;
        if (r < c - p) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] code_of(input int l);
        return (l > 0) ? 2'b01 : (l < 0) ? 2'b11 : 2'b00;
    endfunction

    always @(posedge clk) begin
        int p, c;
        bit cmd;
        int rn;
        p = int'(period);
        if (rst || !en) begin
            m_n <= 0; m_ref <= 0; m_lvl <= 0;
            for (int i = 0; i < 2; i++) begin
                m_run[i] <= 0; m_prev[i] <= 1'b0; m_hi[i] <= 1'b0; m_lo[i] <= 1'b0;
            end
        end else begin
            c = tri_at(m_n, p);
            m_n <= m_n + 1;
            if (c == p) m_ref <= int'(ref_in);
            m_lvl <= level_of(m_ref, c, p);
            for (int i = 0; i < 2; i++) begin
                cmd = (i == 0) ? (m_lvl == 1) : (m_lvl != -1);
                rn = (m_run[i] > 0 && cmd == m_prev[i]) ? m_run[i] + 1 : 1;
                m_run[i]  <= rn;
                m_prev[i] <= cmd;
                m_hi[i]   <= cmd && (rn > int'(dead));
                m_lo[i]   <= !cmd && (rn > int'(dead));
            end
        end
    end

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            string rq, gq;
            if (rst) rq = "R9";
            else if (!en) rq = "R8";
            else if (wobble) rq = "R5";
            else if (m_lvl == 1) rq = "R1 R2";
            else if (m_lvl == -1) rq = "R1 R4";
            else rq = "R1 R3";
            gq = (rst || !en) ? rq : (dead == '0) ? "R6" : "R7";
            n_run++;
            if (state_code !== code_of(m_lvl)) begin
                n_fail++;
                $display("FAIL %s state_code actual=%b expected=%b at %0t",
                         rq, state_code, code_of(m_lvl), $time);
            end
            check_bit(gq, "gate_a_hi", gate_a_hi, m_hi[0]);
            check_bit(gq, "gate_a_lo", gate_a_lo, m_lo[0]);
            check_bit(gq, "gate_b_hi", gate_b_hi, m_hi[1]);
            check_bit(gq, "gate_b_lo", gate_b_lo, m_lo[1]);
            if (gate_a_hi && gate_a_lo) begin
                n_run++; n_fail++;
                $display("FAIL R6 outer pair overlap actual=11 expected=not 11");
            end
        end
    end

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p_list [2] = '{3, 5};
        int d_list [3] = '{0, 1, 3};
        // R9: reset state
        checking = 1'b1;
        cycles(3);
        rst = 1'b0;
        for (int pi = 0; pi < 2; pi++) begin
            for (int di = 0; di < 3; di++) begin
                int p;
                p = p_list[pi];
                en = 1'b0;
                period = CNT_W'(p);
                dead = DT_W'(d_list[di]);
                cycles(3);
                en = 1'b1;
                // Full reference sweep past both ends of the scale, one carrier cycle each
                for (int v = -p - 1; v <= p + 1; v++) begin
                    ref_in = REF_W'(v);
                    cycles(2 * p);
                end
                // R5: reference changes every cycle, only the peak sample counts
                wobble = 1'b1;
                for (int k = 0; k < 4 * p; k++) begin
                    ref_in = REF_W'(((k * 7) % (2 * p + 3)) - p - 1);
                    cycles(1);
                end
                wobble = 1'b0;
                cycles(2 * p);
            end
        end
        // R8: disable mid-run with a positive reference
        ref_in = REF_W'(4);
        cycles(7);
        en = 1'b0;
        cycles(4);
        en = 1'b1;
        cycles(12);
        // R9: reset while running
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(8);
        checking = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule